// File: doc/BRIEF.md
# Pipelined Converter Stage-Code Aligner

This block is the digital back end of one channel of a seven-stage pipelined converter. Six residue stages each resolve a redundant three-level decision, and a final 2-bit flash resolves what is left. The block receives all seven codes. A sample moves on by one stage every half converter clock, so the codes that belong to one sample arrive spread over six half-cycles. The block delays each stage's code by the right number of half-cycles so that all seven line up. It then adds them with binary weights that overlap by one bit, which gives one 8-bit word per converter clock. The overlap absorbs comparator offsets in the residue stages, so those offsets do not reach the output word.

The block runs from a clock at twice the converter rate. A phase strobe marks the half-cycle in which stage 1 presents a new sample's code. Stage k presents its code for that sample k-1 half-cycles later, and the flash presents its code six half-cycles later. A stage code of 0, 1 or 2 stands for the decisions -1, 0 and +1. The value 3 cannot come from a working comparator pair. The block flags it, and a saturating limit keeps the word from wrapping.

Top module: `pipe_code_align`

## Requirements
- R1: While `rst_n` is low, `word_o` is 0 and `bad_o` is 0.
- R2: Let cycle t be a fast-clock cycle in which `phase_i` is 1, carrying stage 1's code for a sample. Stage k's code for that sample is on bits [2k-1:2k-2] of `red_code_i` in cycle t+k-1, and the flash code is on `flash_code_i` in cycle t+6. The word for that sample is on `word_o`/`bad_o` in cycles t+9 and t+10. Counting the sampling edge one half-cycle before cycle t, this is five converter clocks.
- R3: The word is the sum of c1*64 + c2*32 + c3*16 + c4*8 + c5*4 + c6*2 + f, where ck is the raw 2-bit code of stage k and f is the unsigned 2-bit flash code.
- R4: Stage codes can come from ideal residue decisions in which each comparator threshold (nominally at plus and minus one quarter of full scale) is shifted by less than one quarter of full scale. For such codes the word equals floor((x+1)*128), where x is the held input normalised to [-1,1).
- R5: If any stage 1 to 6 code of a sample equals 3, `bad_o` is 1 for that sample's word. Otherwise `bad_o` is 0.
- R6: A sum above 255 gives the word 255, never a wrapped value. The largest valid-code sum (all codes 2, flash 3) is exactly 255 and has `bad_o` 0.
- R7: Stage and flash codes presented in the half-cycles not named in R2 have no effect on any word.
- R8: `word_o` and `bad_o` change only at a clock edge where `phase_i` was 1, so each word is held for two fast cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock at twice the converter sampling rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| phase_i | input | 1 | High in the half-cycle in which stage 1 presents a new sample's code |
| red_code_i | input | 2*N_RED | Redundant stage codes, stage k on bits [2k-1:2k-2] |
| flash_code_i | input | FLASH_W | Final flash code |
| word_o | output | OUT_W | Aligned, corrected output word |
| bad_o | output | 1 | An invalid stage code contributed to `word_o` |

## Verification
Saturation and the invalid-code flag can both act on the same word. The bench builds samples in which a stage holds the code 3 while the other stages are at their maximum, so the limit and the flag fire in the same output cycle. It also builds samples in which the code 3 produces a sum that is still in range, so the flag fires without any limiting. The bench also drives the code 3 on every stage input in every off-phase half-cycle, so any leak of a misaligned code would show up as a spurious flag or a changed word. Every word is compared in both of the fast cycles in which it is held.

// File: rtl/pca_pkg.sv
package pca_pkg;
   localparam int unsigned CODE_W = 2;
   typedef logic [CODE_W-1:0] rcode_t;
   // three-level decision encoding; the fourth value cannot come from a working comparator pair
   localparam rcode_t RC_LOW  = 2'd0;
   localparam rcode_t RC_MID  = 2'd1;
   localparam rcode_t RC_HIGH = 2'd2;
   localparam rcode_t RC_BAD  = 2'd3;
endpackage

// File: rtl/pca_skew_line.sv
module pca_skew_line #(
   parameter int unsigned W     = 2,
   parameter int unsigned DEPTH = 1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d_i,
   output logic [W-1:0] q_o
);
   generate
      if (DEPTH < 1) begin : g_bad_depth
         $error("pca_skew_line: DEPTH must be at least 1");
      end
   endgenerate

   logic [W-1:0] tap_q [DEPTH];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) tap_q[i] <= '0;
      end else begin
         tap_q[0] <= d_i;
         for (int i = 1; i < DEPTH; i++) tap_q[i] <= tap_q[i-1];
      end
   end

   assign q_o = tap_q[DEPTH-1];
endmodule

// File: rtl/pca_merge.sv
module pca_merge
   import pca_pkg::*;
#(
   parameter int unsigned N_RED    = 6,
   parameter int unsigned FLASH_W  = 2,
   parameter int unsigned OUT_W    = N_RED + FLASH_W,
   parameter bit          SATURATE = 1'b1
) (
   input  logic [CODE_W*N_RED-1:0] codes_i,
   input  logic [FLASH_W-1:0]      flash_i,
   output logic [OUT_W-1:0]        word_o,
   output logic                    bad_o
);
   localparam int unsigned SUM_W = OUT_W + 2;
   localparam logic [SUM_W-1:0] FULL = SUM_W'((1 << OUT_W) - 1);

   logic [SUM_W-1:0] acc;
   logic             any_bad;

   // stage k (0-based) carries weight 2^(FLASH_W-1 + N_RED-1-k): one bit of overlap per stage
   always_comb begin
      acc     = SUM_W'(flash_i);
      any_bad = 1'b0;
      for (int k = 0; k < N_RED; k++) begin
         acc     = acc + (SUM_W'(codes_i[CODE_W*k +: CODE_W]) << (FLASH_W - 1 + N_RED - 1 - k));
         any_bad = any_bad | (rcode_t'(codes_i[CODE_W*k +: CODE_W]) == RC_BAD);
      end
   end

   generate
      if (SATURATE) begin : g_sat
         assign word_o = (acc > FULL) ? FULL[OUT_W-1:0] : acc[OUT_W-1:0];
      end else begin : g_wrap
         assign word_o = acc[OUT_W-1:0];
      end
   endgenerate

   assign bad_o = any_bad;
endmodule

// File: rtl/pca_phase_reg.sv
module pca_phase_reg #(
   parameter int unsigned W = 9
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         en_i,
   input  logic [W-1:0] d_i,
   output logic [W-1:0] q_o
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    q_o <= '0;
      else if (en_i) q_o <= d_i;
   end
endmodule

// File: rtl/pipe_code_align.sv
module pipe_code_align
   import pca_pkg::*;
#(
   parameter int unsigned N_RED    = 6,
   parameter int unsigned FLASH_W  = 2,
   parameter int unsigned OUT_W    = N_RED + FLASH_W,
   parameter bit          SATURATE = 1'b1
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    phase_i,
   input  logic [CODE_W*N_RED-1:0] red_code_i,
   input  logic [FLASH_W-1:0]      flash_code_i,
   output logic [OUT_W-1:0]        word_o,
   output logic                    bad_o
);
   localparam int unsigned HOLD_W = OUT_W + 1;

   generate
      if (N_RED < 1)                  begin : g_bad_nred  $error("pipe_code_align: N_RED must be at least 1"); end
      if (FLASH_W < 1)                begin : g_bad_flash $error("pipe_code_align: FLASH_W must be at least 1"); end
      if (OUT_W != N_RED + FLASH_W)   begin : g_bad_outw  $error("pipe_code_align: OUT_W must equal N_RED + FLASH_W"); end
   endgenerate

   logic [CODE_W*N_RED-1:0] aligned_codes;
   logic [OUT_W-1:0]        merged_word;
   logic                    merged_bad;
   logic [HOLD_W-1:0]       sum_q;
   logic [HOLD_W-1:0]       out_q;

   // stage k (0-based) lags stage 0 by k half-cycles; the flash lags by N_RED
   generate
      for (genvar k = 0; k < N_RED; k++) begin : g_stage
         pca_skew_line #(.W(CODE_W), .DEPTH(N_RED - k)) u_skew (
            .clk   (clk),
            .rst_n (rst_n),
            .d_i   (red_code_i[CODE_W*k +: CODE_W]),
            .q_o   (aligned_codes[CODE_W*k +: CODE_W])
         );
      end
   endgenerate

   pca_merge #(.N_RED(N_RED), .FLASH_W(FLASH_W), .OUT_W(OUT_W), .SATURATE(SATURATE)) u_merge (
      .codes_i (aligned_codes),
      .flash_i (flash_code_i),
      .word_o  (merged_word),
      .bad_o   (merged_bad)
   );

   pca_phase_reg #(.W(HOLD_W)) u_sum (
      .clk   (clk),
      .rst_n (rst_n),
      .en_i  (phase_i),
      .d_i   ({merged_bad, merged_word}),
      .q_o   (sum_q)
   );

   pca_phase_reg #(.W(HOLD_W)) u_out (
      .clk   (clk),
      .rst_n (rst_n),
      .en_i  (phase_i),
      .d_i   (sum_q),
      .q_o   (out_q)
   );

   assign word_o = out_q[OUT_W-1:0];
   assign bad_o  = out_q[OUT_W];
endmodule

// File: rtl/pca_checker.sv
module pca_checker #(
   parameter int unsigned N_RED = 6,
   parameter int unsigned OUT_W = 8
) (
   input logic               clk,
   input logic               rst_n,
   input logic               phase_i,
   input logic [2*N_RED-1:0] aligned_i,
   input logic [OUT_W:0]     sum_i,
   input logic [OUT_W-1:0]   word_i,
   input logic               bad_i
);
   logic seen_bad;
   always_comb begin
      seen_bad = 1'b0;
      for (int k = 0; k < N_RED; k++) seen_bad = seen_bad | (aligned_i[2*k +: 2] == 2'd3);
   end

   always @(negedge clk) begin
      if (!rst_n) begin
         AST_RESET_QUIET: assert (word_i == '0 && !bad_i) else $error("output not cleared in reset"); // R1
      end
   end

   AST_LATCH_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
      phase_i |=> ({bad_i, word_i} == $past(sum_i))) else $error("output latch missed sum"); // R2

   AST_BAD_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
      (phase_i && seen_bad) |=> sum_i[OUT_W]) else $error("invalid code not flagged"); // R5

   AST_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
      phase_i |=> (sum_i[OUT_W-1:0] >= {$past(aligned_i[1:0]), {(OUT_W-2){1'b0}}})) else $error("sum wrapped"); // R6

   AST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !phase_i |=> ($stable(word_i) && $stable(bad_i))) else $error("output moved off phase"); // R8
endmodule

bind pipe_code_align pca_checker #(.N_RED(N_RED), .OUT_W(OUT_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .phase_i   (phase_i),
   .aligned_i (aligned_codes),
   .sum_i     (sum_q),
   .word_i    (word_o),
   .bad_i     (bad_o)
);

// File: tb/pipe_code_align_tb.sv
module pipe_code_align_tb;
   localparam int NS = 200;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        phase = 1'b0;
   logic [11:0] red = '0;
   logic [1:0]  flash = '0;
   logic [7:0]  word;
   logic        bad;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   int    sc [NS][6];
   int    sf [NS];
   int    ew [NS];
   bit    eb [NS];
   string tag [NS];

   always #4 clk = ~clk;

   pipe_code_align u_dut (
      .clk          (clk),
      .rst_n        (rst_n),
      .phase_i      (phase),
      .red_code_i   (red),
      .flash_code_i (flash),
      .word_o       (word),
      .bad_o        (bad)
   );

   // R3 formula, R5 flag and R6 limit, from the requirement text
   task automatic add_direct(input int n, input int c0, input int c1, input int c2,
                             input int c3, input int c4, input int c5, input int f, input string t);
      int cs [6];
      int s;
      cs = '{c0, c1, c2, c3, c4, c5};
      s = f;
      eb[n] = 1'b0;
      for (int k = 0; k < 6; k++) begin
         sc[n][k] = cs[k];
         s += cs[k] * (1 << (6 - k));
         if (cs[k] == 3) eb[n] = 1'b1;
      end
      sf[n]  = f;
      ew[n]  = (s > 255) ? 255 : s;
      tag[n] = t;
   endtask

   // R4: ideal residue decisions with shifted thresholds, input in units of 1/1024
   task automatic add_ideal(input int n);
      int x, r, d, hi, lo;
      x = int'($urandom_range(2047, 0)) - 1024;
      r = x;
      for (int k = 0; k < 6; k++) begin
         hi = 256 + int'($urandom_range(400, 0)) - 200;
         lo = -256 + int'($urandom_range(400, 0)) - 200;
         if (r > hi)      d = 1;
         else if (r < lo) d = -1;
         else             d = 0;
         sc[n][k] = d + 1;
         r = 2 * r - d * 1024;
      end
      sf[n]  = (r + 1024) / 512;
      ew[n]  = (x + 1024) / 8;
      eb[n]  = 1'b0;
      tag[n] = "R4";
   endtask

   task automatic check_word(input int n, input string when);
      checks++;
      if (word !== 8'(ew[n]) || bad !== eb[n]) begin
         errors++;
         $display("FAIL %s %s sample %0d: word=%0d bad=%0b expected word=%0d bad=%0b",
                  when, tag[n], n, word, bad, ew[n], eb[n]);
      end
   endtask

   initial begin
      int n;
      n = 0;
      add_direct(n++, 1,1,1,1,1,1, 0, "R3 mid");
      add_direct(n++, 1,1,1,1,1,1, 1, "R3 mid");
      add_direct(n++, 1,1,1,1,1,1, 2, "R3 mid");
      add_direct(n++, 1,1,1,1,1,1, 3, "R3 mid");
      add_direct(n++, 0,0,0,0,0,0, 0, "R3 floor");
      add_direct(n++, 2,2,2,2,2,2, 3, "R3 R6 top");
      add_direct(n++, 2,0,0,0,0,0, 0, "R3 weight");
      add_direct(n++, 0,2,0,0,0,0, 0, "R3 weight");
      add_direct(n++, 0,0,2,0,0,0, 0, "R3 weight");
      add_direct(n++, 0,0,0,2,0,0, 0, "R3 weight");
      add_direct(n++, 0,0,0,0,2,0, 0, "R3 weight");
      add_direct(n++, 0,0,0,0,0,2, 0, "R3 weight");
      add_direct(n++, 2,0,2,0,2,0, 2, "R3 R7 alt");
      add_direct(n++, 3,2,2,2,2,2, 3, "R5 R6 clamp");
      add_direct(n++, 2,2,3,2,2,2, 3, "R5 R6 clamp");
      add_direct(n++, 0,0,0,0,0,3, 0, "R5 in range");
      add_direct(n++, 3,0,0,0,0,0, 1, "R5 R6 no clamp");
      add_direct(n++, 1,1,1,1,1,1, 0, "R7 after bad");
      while (n < NS) begin
         add_ideal(n);
         n++;
      end

      repeat (3) @(negedge clk);
      checks++;
      if (word !== 8'd0 || bad !== 1'b0) begin
         errors++;
         $display("FAIL R1 reset: word=%0d bad=%0b expected word=0 bad=0", word, bad);
      end
      rst_n = 1'b1;

      for (int c = 0; c < 2 * NS + 9; c++) begin
         @(negedge clk);
         if (c >= 9) begin
            int m;
            m = (c - 9) / 2;
            if (m < NS) check_word(m, (c % 2 == 1) ? "R2" : "R8");
         end
         phase = (c % 2 == 0);
         // R7: every off-phase half-cycle carries the invalid code on all stages
         for (int k = 0; k < 6; k++) begin
            int s;
            s = c - k;
            if (s >= 0 && s % 2 == 0 && s / 2 < NS) red[2*k +: 2] = 2'(sc[s/2][k]);
            else                                     red[2*k +: 2] = 2'd3;
         end
         begin
            int s;
            s = c - 6;
            if (s >= 0 && s % 2 == 0 && s / 2 < NS) flash = 2'(sf[s/2]);
            else                                     flash = 2'($urandom_range(3, 0));
         end
      end
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (5000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog expired");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule